// File: doc/BRIEF.md
# Earliest-Deadline Timer Event Scheduler

This block keeps a small table of timed events and always exposes the one due first on a single compare output. A sibling block supplies a free-running 24-bit tick counter. The scheduler watches that counter for wraps and keeps an overflow count, so every timestamp it handles is 64 bits wide: the overflow count sits above bit 24 and the live counter sits below it.

Slot 0 is never handed out. It holds a built-in overflow event whose deadline is always the next counter wrap. When the wrap arrives, the overflow count advances and the event re-arms for the following wrap. The remaining slots take user events, each with a timestamp and a parameter word. Callers can schedule an event, cancel one by slot id, or cancel every event whose parameter matches a value. An event that is already due, or that falls within a short setup window of the current time, is expired straight away instead of being programmed. Each expiry appears as a one-cycle pulse that carries the slot and the parameter. Whatever acts on the expiry lives outside the block.

Top module: `evs_sched`

## Requirements
- R1: After reset the timestamp output reads 0, no expiry pulse is asserted, and the compare output shows slot 0 with time 2^24.
- R2: The timestamp output equals (overflow count << 24) | counter. A wrap is seen in the same cycle the counter value drops, and it advances the count. One cycle later it produces an expiry pulse for slot 0 with parameter 0, and slot 0 re-arms with deadline (count + 1) << 24. Slot 0 never expires before the wrap.
- R3: A schedule request takes the lowest free slot from 1 upward and returns its id in the same cycle. The id port is clog2(N)+1 bits wide. When no slot is free the returned id is 0, and 0 means invalid.
- R4: The compare output shows the valid slot with the smallest timestamp. On a tie it shows the lowest index.
- R5: A user event whose timestamp is at most current time + SETUP_TICKS (default 10) is expired without being programmed. At most one event expires per cycle, earliest first, so a group of overdue events drains over successive cycles. The comparison uses the full 64-bit time.
- R6: Cancel by id reports not-found for id 0, for ids of N or more, and for empty slots. Otherwise it reports success and frees the slot. Cancelling the programmed event moves the compare output to the next earliest event.
- R7: Cancel by parameter frees every user slot whose parameter matches. It reports success when at least one slot matched.
- R8: An expiry pulse lasts exactly one cycle. It rises on the clock edge at which the event became due and carries the slot index and the parameter. The slot is free from that edge on.
- R9: A newly scheduled event that is earlier than the programmed one takes over the compare output one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_in | input | 24 | Live tick counter from the sibling counter block |
| sched_req | input | 1 | Schedule request strobe |
| sched_ts | input | 64 | Absolute timestamp of the new event |
| sched_par | input | 32 | Parameter word of the new event |
| sched_id | output | 4 | Slot granted (0 = invalid), valid while sched_req is high |
| kill_req | input | 1 | Cancel-by-id strobe |
| kill_id | input | 4 | Slot to cancel |
| kill_ok | output | 1 | Cancel-by-id success |
| pkill_req | input | 1 | Cancel-by-parameter strobe |
| pkill_par | input | 32 | Parameter value to match |
| pkill_ok | output | 1 | At least one slot matched |
| exp_valid | output | 1 | One-cycle expiry pulse |
| exp_slot | output | 3 | Slot that expired |
| exp_par | output | 32 | Parameter of the expired event |
| cmp_slot | output | 3 | Slot currently programmed on the compare channel |
| cmp_time | output | 64 | Timestamp currently programmed |
| ts_now | output | 64 | Extended current timestamp |

## Verification
The hardest case to reach from the ports is the counter wrap. Slot 0's deadline lies near 2^24 ticks, which the bench could never reach by counting. Because the bench drives the counter itself, it jumps the counter to a few ticks before the wrap, confirms that slot 0 does not fire early even inside the setup window, and then drops the counter to produce the wrap. A user event scheduled just past the new overflow boundary then checks that the 64-bit comparison holds across the carry. A sweep of setup offsets from 0 to 20 finds the exact edge of the too-close window.

// File: rtl/evs_pkg.sv
package evs_pkg;

    localparam int CNT_W = 24;
    localparam int TS_W  = 64;
    localparam int PAR_W = 32;
    localparam int OVF_W = TS_W - CNT_W;

    typedef logic [TS_W-1:0]  ts_t;
    typedef logic [PAR_W-1:0] par_t;
    typedef logic [OVF_W-1:0] ovf_t;

    typedef struct packed {
        logic vld;
        ts_t  ts;
        par_t par;
    } slot_t;

    function automatic ts_t join_time(input ovf_t ovf, input logic [CNT_W-1:0] cnt);
        return {ovf, cnt};
    endfunction

    function automatic logic within_setup(input ts_t ts, input ts_t now, input int unsigned win);
        return ts <= now + TS_W'(win);
    endfunction

endpackage

// File: rtl/evs_freepick.sv
module evs_freepick #(
    parameter int N_SLOTS = 8,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] vld,
    output logic               found,
    output logic [SLOT_W-1:0]  idx
);
    // descending scan: the last hit written is the lowest free index >= 1
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_SLOTS - 1; i >= 0; i--) begin
            if (!vld[i] && i != 0) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/evs_minsel.sv
module evs_minsel
    import evs_pkg::*;
#(
    parameter int N_SLOTS = 8,
    localparam int SLOT_W = $clog2(N_SLOTS)
) (
    input  logic [N_SLOTS-1:0] vld,
    input  ts_t                ts_i [N_SLOTS],
    output logic               best_v,
    output logic [SLOT_W-1:0]  best_idx,
    output ts_t                best_ts
);
    // ascending scan with strict compare keeps the lowest index on ties
    always_comb begin
        best_v   = 1'b0;
        best_idx = '0;
        best_ts  = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (vld[i] && (!best_v || ts_i[i] < best_ts)) begin
                best_v   = 1'b1;
                best_idx = SLOT_W'(i);
                best_ts  = ts_i[i];
            end
        end
    end
endmodule

// File: rtl/evs_sched.sv
module evs_sched
    import evs_pkg::*;
#(
    parameter int N_SLOTS     = 8,
    parameter int SETUP_TICKS = 10,
    localparam int SLOT_W     = $clog2(N_SLOTS),
    localparam int ID_W       = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic              sched_req,
    input  logic [TS_W-1:0]   sched_ts,
    input  logic [PAR_W-1:0]  sched_par,
    output logic [ID_W-1:0]   sched_id,
    input  logic              kill_req,
    input  logic [ID_W-1:0]   kill_id,
    output logic              kill_ok,
    input  logic              pkill_req,
    input  logic [PAR_W-1:0]  pkill_par,
    output logic              pkill_ok,
    output logic              exp_valid,
    output logic [SLOT_W-1:0] exp_slot,
    output logic [PAR_W-1:0]  exp_par,
    output logic [SLOT_W-1:0] cmp_slot,
    output logic [TS_W-1:0]   cmp_time,
    output logic [TS_W-1:0]   ts_now
);

    // time base: wrap seen in the same cycle the counter drops
    ovf_t             ovf_q, ovf_eff;
    logic [CNT_W-1:0] cnt_prev;
    logic             wrap;
    ts_t              now, deadline0;

    assign wrap      = cnt_in < cnt_prev;
    assign ovf_eff   = ovf_q + OVF_W'(wrap);
    assign now       = join_time(ovf_eff, cnt_in);
    assign deadline0 = join_time(ovf_q + 1'b1, '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q    <= '0;
            cnt_prev <= '0;
        end else begin
            ovf_q    <= ovf_eff;
            cnt_prev <= cnt_in;
        end
    end

    // slot table view (slot 0 is the virtual overflow event)
    logic [N_SLOTS-1:0] view_vld, pmatch;
    ts_t                view_ts  [N_SLOTS];
    par_t               view_par [N_SLOTS];

    logic              best_v, free_ok, take_new, fire_user;
    logic [SLOT_W-1:0] best_idx, free_idx, kslot;
    ts_t               best_ts;
    logic              kill_range;

    evs_freepick #(.N_SLOTS(N_SLOTS)) u_free (
        .vld  (view_vld),
        .found(free_ok),
        .idx  (free_idx)
    );

    evs_minsel #(.N_SLOTS(N_SLOTS)) u_min (
        .vld     (view_vld),
        .ts_i    (view_ts),
        .best_v  (best_v),
        .best_idx(best_idx),
        .best_ts (best_ts)
    );

    assign take_new   = sched_req && free_ok;
    assign sched_id   = take_new ? {1'b0, free_idx} : '0;

    assign kill_range = (kill_id != '0) && (kill_id < ID_W'(N_SLOTS));
    assign kslot      = kill_id[SLOT_W-1:0];
    assign kill_ok    = kill_req && kill_range && view_vld[kslot];

    assign pkill_ok   = pkill_req && (|pmatch);

    assign fire_user  = !wrap && best_v && (best_idx != '0)
                        && within_setup(best_ts, now, SETUP_TICKS);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        if (g == 0) begin : g_ovf
            assign view_vld[g] = 1'b1;
            assign view_ts[g]  = deadline0;
            assign view_par[g] = '0;
            assign pmatch[g]   = 1'b0;
        end else begin : g_user
            slot_t ent;
            logic  drop;

            assign drop = (kill_ok && kslot == SLOT_W'(g))
                        || (pkill_req && pmatch[g])
                        || (fire_user && best_idx == SLOT_W'(g));

            always_ff @(posedge clk) begin
                if (rst) begin
                    ent <= '0;
                end else if (take_new && free_idx == SLOT_W'(g)) begin
                    ent <= '{vld: 1'b1, ts: sched_ts, par: sched_par};
                end else if (drop) begin
                    ent.vld <= 1'b0;
                end
            end

            assign view_vld[g] = ent.vld;
            assign view_ts[g]  = ent.ts;
            assign view_par[g] = ent.par;
            assign pmatch[g]   = ent.vld && (ent.par == pkill_par);
        end
    end

    // expiry pulse: the wrap outranks a due user event in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            exp_valid <= 1'b0;
            exp_slot  <= '0;
            exp_par   <= '0;
        end else begin
            exp_valid <= wrap || fire_user;
            exp_slot  <= wrap ? '0 : best_idx;
            exp_par   <= wrap ? '0 : view_par[best_idx];
        end
    end

    assign cmp_slot = best_idx;
    assign cmp_time = best_ts;
    assign ts_now   = now;

endmodule

// File: rtl/evs_sched_chk.sv
module evs_sched_chk
    import evs_pkg::*;
#(
    parameter int N_SLOTS     = 8,
    parameter int SETUP_TICKS = 10,
    localparam int SLOT_W     = $clog2(N_SLOTS),
    localparam int ID_W       = SLOT_W + 1
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt_in,
    input logic              sched_req,
    input logic [ID_W-1:0]   sched_id,
    input logic              kill_req,
    input logic [ID_W-1:0]   kill_id,
    input logic              kill_ok,
    input logic              exp_valid,
    input logic [SLOT_W-1:0] exp_slot,
    input logic [SLOT_W-1:0] cmp_slot,
    input logic [TS_W-1:0]   cmp_time,
    input logic [TS_W-1:0]   ts_now
);
    logic seen_run;
    always_ff @(posedge clk) seen_run <= !rst;

    // R3: a granted id is always a user slot inside the table
    p_grant_range_r3: assert property (@(posedge clk) disable iff (rst)
        (sched_req && sched_id != '0) |-> (sched_id < ID_W'(N_SLOTS)));

    // R6: reserved and out-of-range ids are never accepted
    p_kill_reject_r6: assert property (@(posedge clk) disable iff (rst)
        (kill_req && (kill_id == '0 || kill_id >= ID_W'(N_SLOTS))) |-> !kill_ok);

    // R4: a user expiry is always the event that was on the compare channel
    p_from_cmp_r4: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && exp_slot != '0) |-> (exp_slot == $past(cmp_slot)));

    // R5: a user expiry only happens inside the setup window
    p_due_window_r5: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && exp_slot != '0)
        |-> ($past(cmp_time) <= $past(ts_now) + TS_W'(SETUP_TICKS)));

    // R2: a counter drop carries exactly one into the upper timestamp bits
    p_wrap_carry_r2: assert property (@(posedge clk) disable iff (rst)
        (seen_run && cnt_in < $past(cnt_in))
        |-> (ts_now[TS_W-1:CNT_W] == $past(ts_now[TS_W-1:CNT_W]) + 1'b1));

    // R8: the same user slot cannot expire on two adjacent cycles
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        (exp_valid && exp_slot != '0) |=> !(exp_valid && exp_slot == $past(exp_slot)));

endmodule

bind evs_sched evs_sched_chk #(.N_SLOTS(N_SLOTS), .SETUP_TICKS(SETUP_TICKS)) u_chk (.*);

// File: tb/evs_sched_test.sv
module evs_sched_test;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] cnt_in = '0;
    logic        sched_req = 1'b0;
    logic [63:0] sched_ts = '0;
    logic [31:0] sched_par = '0;
    logic [3:0]  sched_id;
    logic        kill_req = 1'b0;
    logic [3:0]  kill_id = '0;
    logic        kill_ok;
    logic        pkill_req = 1'b0;
    logic [31:0] pkill_par = '0;
    logic        pkill_ok;
    logic        exp_valid;
    logic [2:0]  exp_slot;
    logic [31:0] exp_par;
    logic [2:0]  cmp_slot;
    logic [63:0] cmp_time;
    logic [63:0] ts_now;

    int n_chk = 0;
    int n_err = 0;

    evs_sched uut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_sched(input logic [63:0] ts, input logic [31:0] par, output logic [3:0] id);
        sched_req = 1'b1; sched_ts = ts; sched_par = par;
        #1 id = sched_id;
        @(negedge clk);
        sched_req = 1'b0;
    endtask

    task automatic do_kill(input logic [3:0] id, output logic ok);
        kill_req = 1'b1; kill_id = id;
        #1 ok = kill_ok;
        @(negedge clk);
        kill_req = 1'b0;
    endtask

    task automatic do_pkill(input logic [31:0] par, output logic ok);
        pkill_req = 1'b1; pkill_par = par;
        #1 ok = pkill_ok;
        @(negedge clk);
        pkill_req = 1'b0;
    endtask

    initial begin
        #(CLK_P * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [3:0]  id;
        logic        ok;
        logic [63:0] c;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 ts_now", ts_now, 64'd0);
        check("R1 exp_valid", exp_valid, 0);
        check("R1 cmp_slot", cmp_slot, 0);
        check("R1 cmp_time", cmp_time, 64'h1000000);
        @(negedge clk);

        // R5 / R8 sweep of the setup window edge
        cnt_in = 24'd5000;
        for (int d = 0; d <= 20; d++) begin
            do_sched(64'd5000 + 64'(d), 32'(100 + d), id);
            check("R3 lowest slot", id, 1);
            @(negedge clk);
            check("R5 window edge", exp_valid, (d <= 10) ? 1 : 0);
            if (d <= 10) begin
                check("R8 exp slot", exp_slot, 1);
                check("R8 exp par", exp_par, 64'(100 + d));
            end
            @(negedge clk);
            check("R8 one cycle", exp_valid, 0);
            do_kill(4'd1, ok);
            check("R6 kill after window", ok, (d > 10) ? 1 : 0);
        end

        // R3 fill the table
        for (int i = 1; i < 8; i++) begin
            do_sched(64'd100000 + 64'(i * 10), 32'(i), id);
            check("R3 fill id", id, 64'(i));
        end
        do_sched(64'd200, 32'd99, id);
        check("R3 full gives 0", id, 0);
        check("R4 earliest of full table", cmp_slot, 1);
        for (int i = 1; i < 8; i++) begin
            do_kill(4'(i), ok);
            check("R6 kill valid", ok, 1);
        end
        #1;
        check("R6 empty table cmp", cmp_slot, 0);
        check("R6 empty table time", cmp_time, 64'h1000000);

        // R4 ties and R5 drain order
        c = 64'd20000;
        cnt_in = 24'd20000;
        do_sched(c + 5000, 32'hA, id); check("R3 id1", id, 1);
        do_sched(c + 3000, 32'hB, id); check("R3 id2", id, 2);
        do_sched(c + 4000, 32'hC, id); check("R3 id3", id, 3);
        do_sched(c + 3000, 32'hD, id); check("R3 id4", id, 4);
        #1;
        check("R4 tie lowest index", cmp_slot, 2);
        check("R4 tie time", cmp_time, c + 3000);
        cnt_in = 24'd26000;
        @(negedge clk);
        check("R5 drain 1 slot", exp_slot, 2); check("R5 drain 1 par", exp_par, 32'hB);
        check("R5 drain 1 valid", exp_valid, 1);
        @(negedge clk);
        check("R5 drain 2 slot", exp_slot, 4); check("R5 drain 2 par", exp_par, 32'hD);
        @(negedge clk);
        check("R5 drain 3 slot", exp_slot, 3); check("R5 drain 3 par", exp_par, 32'hC);
        @(negedge clk);
        check("R5 drain 4 slot", exp_slot, 1); check("R5 drain 4 par", exp_par, 32'hA);
        check("R5 drain 4 valid", exp_valid, 1);
        @(negedge clk);
        check("R8 drained", exp_valid, 0);
        check("R8 slots freed", cmp_slot, 0);

        // R9 reselection and R6 cancel rules
        c = 64'd30000;
        cnt_in = 24'd30000;
        do_sched(c + 9000, 32'd1, id); check("R3 id", id, 1);
        check("R9 first programmed", cmp_slot, 1);
        do_sched(c + 8000, 32'd2, id); check("R3 id", id, 2);
        check("R9 earlier takes over", cmp_slot, 2);
        check("R9 time", cmp_time, c + 8000);
        do_kill(4'd0, ok); check("R6 reject id 0", ok, 0);
        do_kill(4'd9, ok); check("R6 reject out of range", ok, 0);
        do_kill(4'd3, ok); check("R6 reject empty", ok, 0);
        do_kill(4'd2, ok); check("R6 kill programmed", ok, 1);
        #1 check("R6 falls back", cmp_slot, 1);
        do_kill(4'd1, ok); check("R6 kill last", ok, 1);

        // R7 cancel by parameter
        do_sched(c + 20000, 32'h55, id); check("R3 id", id, 1);
        do_sched(c + 21000, 32'h66, id); check("R3 id", id, 2);
        do_sched(c + 22000, 32'h55, id); check("R3 id", id, 3);
        do_pkill(32'h55, ok); check("R7 match found", ok, 1);
        do_kill(4'd1, ok); check("R7 slot1 gone", ok, 0);
        do_kill(4'd3, ok); check("R7 slot3 gone", ok, 0);
        do_kill(4'd2, ok); check("R7 other kept", ok, 1);
        do_pkill(32'h55, ok); check("R7 no match", ok, 0);

        // R2 overflow wrap
        cnt_in = 24'hFFFFF8;
        @(negedge clk);
        check("R2 no early slot0", exp_valid, 0);
        check("R2 ts join", ts_now, 64'h0000_0000_00FF_FFF8);
        @(negedge clk);
        check("R2 still no slot0", exp_valid, 0);
        cnt_in = 24'd3;
        #1 check("R2 wrap same cycle", ts_now, 64'h0000_0000_0100_0003);
        @(negedge clk);
        check("R2 slot0 pulse", exp_valid, 1);
        check("R2 slot0 id", exp_slot, 0);
        check("R2 slot0 par", exp_par, 0);
        check("R2 rearm", cmp_time, 64'h200_0000);
        check("R2 ts after", ts_now, 64'h0000_0000_0100_0003);
        do_sched(64'h100_0032, 32'h77, id);
        check("R2 slot0 one pulse", exp_valid, 0);
        check("R3 id after wrap", id, 1);
        @(negedge clk);
        check("R5 64-bit not due", exp_valid, 0);
        cnt_in = 24'd45;
        @(negedge clk);
        check("R5 64-bit due", exp_valid, 1);
        check("R5 64-bit slot", exp_slot, 1);
        check("R5 64-bit par", exp_par, 32'h77);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule